// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps a per-vector interrupt message table and the matching pending bits for one PCIe function. Software sees both through a 32-bit register port on a 4 KiB window of the device's memory space. The table sits at the bottom of the window. The pending bits occupy a read-only window that starts halfway through it. The function-wide enable and mask-all bits come in from the capability control register that lives elsewhere.

When device logic raises an interrupt on a vector, the block looks at that vector's mask state. If the vector may deliver, the block emits one message write with the stored address and data. If not, it records the interrupt in the pending bit. Deferred interrupts go out as soon as their vector becomes deliverable. This can happen through a table write that clears the entry's mask bit, through the mask-all bit falling, or through the enable bit rising. The block also reports the constant capability fields: the table size and the two offset words, each carrying its region index.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, every entry's control word reads 1 (masked), every address and data word reads 0, the pending window reads 0, and no message is emitted.
- R2: Entry v occupies bytes 16*v to 16*v+15. Address low is at +0, address high at +4, data at +8 and vector control at +12. Only bit 0 of vector control (the mask bit) is stored; its other bits read 0. Read data appears with rd_valid one cycle after the request.
- R3: An interrupt on an in-range vector goes out as a message in the following cycle, with msg_addr = {address high, address low} and msg_data = data. This happens when func_en=1, func_mask_all=0, the entry's mask bit is 0 and no deferred release goes out in the same cycle.
- R4: An interrupt on a vector whose mask bit is set, or while func_mask_all=1, or while func_en=0, emits no message and sets that vector's pending bit.
- R5: The pending window starts at byte offset 2048. Its 32-bit word k holds the pending bits of vectors 32k to 32k+31, with vector v at bit v mod 32. The window is ceil(N/64)*8 bytes long. Reads beyond it return 0, and writes anywhere in it change nothing.
- R6: Clearing the mask bit of a pending vector, while the function is enabled and not mask-all'd, emits that vector's message in the cycle after the write takes effect and clears its pending bit.
- R7: When func_mask_all falls or func_en rises, deliverable pending vectors are emitted one per cycle, lowest vector index first, and their pending bits are cleared.
- R8: When a deferred release and a new interrupt on another deliverable vector fall in the same cycle, the release goes first and the new interrupt is made pending, then emitted in a later cycle.
- R9: Table offsets of entries at or beyond the vector count read 0 and ignore writes. Interrupts with irq_vec at or beyond the vector count are ignored.
- R10: A sub-word access (req_full=0) to either window writes nothing and reads 0.
- R11: cap_qsize equals the vector count minus one. cap_table_word equals 0 with the region index in bits 2:0. cap_pba_word equals 2048 with the region index in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_en | input | 1 | Function-wide enable from capability control |
| func_mask_all | input | 1 | Function-wide mask from capability control |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | 1 = full 4-byte access |
| req_addr | input | 12 | Byte offset within the 4 KiB window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | $clog2(NUM_VEC)+1 | Requested vector |
| msg_valid | output | 1 | Message write strobe |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| cap_qsize | output | 11 | Vector count minus one |
| cap_table_word | output | 32 | Table offset and region index |
| cap_pba_word | output | 32 | Pending offset and region index |

## Verification
The bench builds the block with eight vectors and region index 2. With eight vectors, every entry can be swept one by one for table layout, deferral and release on unmask, and the irq_vec width still reaches the out-of-range vector 8. The pending window is then one 64-bit unit long, so its unused upper word and the first offset past it are both within reach. Release ordering on mask-all, release on enable, and collision with a fresh interrupt are driven at exact cycle offsets from the write that unmasks.

// File: rtl/msix_pkg.sv
package msix_pkg;
    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        mask;
    } msix_entry_t;

    localparam msix_entry_t ENTRY_RST = '{addr_lo: 32'h0, addr_hi: 32'h0, data: 32'h0, mask: 1'b1};

    localparam int WIN_AW       = 12;
    localparam int PBA_BYTE_OFF = 2048;
    localparam int ENT_BYTES    = 16;
endpackage

// File: rtl/msix_pick.sv
module msix_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/msix_pend_win.sv
module msix_pend_win #(
    parameter int N  = 8,
    parameter int WW = 9
) (
    input  logic [N-1:0]  pend,
    input  logic [WW-1:0] word_idx,
    output logic [31:0]   word
);
    localparam int PWORDS = ((N + 63) / 64) * 2;

    logic [PWORDS*32-1:0] padded;

    always_comb begin
        padded = '0;
        padded[N-1:0] = pend;
        word = '0;
        for (int k = 0; k < PWORDS; k++) begin
            if (word_idx == WW'(k)) word = padded[k*32 +: 32];
        end
    end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
    import msix_pkg::*;
#(
    parameter int          NUM_VEC = 8,
    parameter logic [2:0]  REGION  = 3'd0,
    localparam int         VW      = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int         IVW     = VW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              func_en,
    input  logic              func_mask_all,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_full,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              irq_valid,
    input  logic [IVW-1:0]    irq_vec,
    output logic              msg_valid,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data,
    output logic [10:0]       cap_qsize,
    output logic [31:0]       cap_table_word,
    output logic [31:0]       cap_pba_word
);
    localparam int EIW = WIN_AW - 1 - 4;   // entry index bits inside table half
    localparam int PWW = WIN_AW - 1 - 2;   // word index bits inside pending half

    initial begin
        assert_size_fits_R5: assert (NUM_VEC >= 2 && NUM_VEC * ENT_BYTES <= PBA_BYTE_OFF);
    end

    typedef struct {
        msix_entry_t          tbl [NUM_VEC];
        logic [NUM_VEC-1:0]   pend;
        logic                 msg_v;
        logic [63:0]          msg_a;
        logic [31:0]          msg_d;
        logic                 rd_v;
        logic [31:0]          rd_d;
    } state_t;

    state_t s_d, s_q;

    // ---- mask evaluation and release selection (state before this cycle's write)
    logic [NUM_VEC-1:0] vmask;
    logic [NUM_VEC-1:0] rel_req;
    logic               rel_found;
    logic [VW-1:0]      rel_idx;

    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) vmask[v] = func_mask_all | s_q.tbl[v].mask;
        rel_req = s_q.pend & ~vmask & {NUM_VEC{func_en}};
    end

    msix_pick #(.N(NUM_VEC), .IW(VW)) u_pick (
        .req   (rel_req),
        .found (rel_found),
        .idx   (rel_idx)
    );

    // ---- address decode
    logic             in_pba;
    logic [EIW-1:0]   ent_raw;
    logic             ent_ok;
    logic [VW-1:0]    ent;
    logic [1:0]       wsel;
    logic [31:0]      pba_word;
    logic             irq_ok;
    logic [VW-1:0]    ivec;

    always_comb begin
        in_pba  = req_addr[WIN_AW-1];
        ent_raw = req_addr[WIN_AW-2:4];
        ent_ok  = ({1'b0, ent_raw} < (EIW+1)'(NUM_VEC));
        ent     = ent_raw[VW-1:0];
        wsel    = req_addr[3:2];
        irq_ok  = ({1'b0, irq_vec} < (IVW+1)'(NUM_VEC));
        ivec    = irq_vec[VW-1:0];
    end

    msix_pend_win #(.N(NUM_VEC), .WW(PWW)) u_pwin (
        .pend     (s_q.pend),
        .word_idx (req_addr[WIN_AW-2:2]),
        .word     (pba_word)
    );

    // ---- next state
    always_comb begin
        s_d       = s_q;
        s_d.msg_v = 1'b0;
        s_d.rd_v  = 1'b0;
        s_d.rd_d  = '0;

        // deferred release has priority
        if (rel_found) begin
            s_d.msg_v         = 1'b1;
            s_d.msg_a         = {s_q.tbl[rel_idx].addr_hi, s_q.tbl[rel_idx].addr_lo};
            s_d.msg_d         = s_q.tbl[rel_idx].data;
            s_d.pend[rel_idx] = 1'b0;
        end

        if (irq_valid && irq_ok) begin
            if (!func_en || vmask[ivec] || rel_found) begin
                if (!(rel_found && rel_idx == ivec)) s_d.pend[ivec] = 1'b1;
            end else begin
                s_d.msg_v = 1'b1;
                s_d.msg_a = {s_q.tbl[ivec].addr_hi, s_q.tbl[ivec].addr_lo};
                s_d.msg_d = s_q.tbl[ivec].data;
            end
        end

        if (req_valid && req_write && req_full && !in_pba && ent_ok) begin
            case (wsel)
                2'd0:    s_d.tbl[ent].addr_lo = req_wdata;
                2'd1:    s_d.tbl[ent].addr_hi = req_wdata;
                2'd2:    s_d.tbl[ent].data    = req_wdata;
                default: s_d.tbl[ent].mask    = req_wdata[0];
            endcase
        end

        if (req_valid && !req_write) begin
            s_d.rd_v = 1'b1;
            if (req_full) begin
                if (in_pba) begin
                    s_d.rd_d = pba_word;
                end else if (ent_ok) begin
                    case (wsel)
                        2'd0:    s_d.rd_d = s_q.tbl[ent].addr_lo;
                        2'd1:    s_d.rd_d = s_q.tbl[ent].addr_hi;
                        2'd2:    s_d.rd_d = s_q.tbl[ent].data;
                        default: s_d.rd_d = {31'h0, s_q.tbl[ent].mask};
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VEC; v++) s_q.tbl[v] <= ENTRY_RST;
            s_q.pend  <= '0;
            s_q.msg_v <= 1'b0;
            s_q.msg_a <= '0;
            s_q.msg_d <= '0;
            s_q.rd_v  <= 1'b0;
            s_q.rd_d  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid       = s_q.rd_v;
    assign rd_data        = s_q.rd_d;
    assign msg_valid      = s_q.msg_v;
    assign msg_addr       = s_q.msg_a;
    assign msg_data       = s_q.msg_d;
    assign cap_qsize      = 11'(NUM_VEC - 1);
    assign cap_table_word = {29'h0, REGION};
    assign cap_pba_word   = 32'(PBA_BYTE_OFF) | {29'h0, REGION};

    // ---- assertions
    assert_msg_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($past(func_en) && !$past(func_mask_all)));

    assert_one_new_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.pend & ~$past(s_q.pend)) <= 1);

    assert_pending_needs_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(irq_valid) |-> ((s_q.pend & ~$past(s_q.pend)) == '0));

    assert_read_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    assert_release_one_per_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(s_q.pend) & ~s_q.pend) <= 1);
endmodule

// File: tb/msix_vec_ctrl_tb.sv
`timescale 1ns/1ps
module msix_vec_ctrl_tb;
    localparam int NV = 8;
    localparam logic [2:0] RG = 3'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic func_en = 1'b0, func_mask_all = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_full = 1'b1;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic irq_valid = 1'b0;
    logic [3:0] irq_vec = '0;
    logic msg_valid;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [10:0] cap_qsize;
    logic [31:0] cap_table_word, cap_pba_word;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    msix_vec_ctrl #(.NUM_VEC(NV), .REGION(RG)) u_dut (
        .clk(clk), .rst_n(rst_n), .func_en(func_en), .func_mask_all(func_mask_all),
        .req_valid(req_valid), .req_write(req_write), .req_full(req_full),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data), .cap_qsize(cap_qsize),
        .cap_table_word(cap_table_word), .cap_pba_word(cap_pba_word)
    );

    function automatic logic [31:0] a_lo(int v); return 32'h4000_0000 + 32'(v) * 32'h100; endfunction
    function automatic logic [31:0] a_hi(int v); return 32'h0000_00A0 + 32'(v); endfunction
    function automatic logic [31:0] dat(int v);  return 32'hCAFE_0000 + 32'(v); endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic full = 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_full = full;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_full = 1'b1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic full = 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_full = full;
        @(negedge clk);
        req_valid = 1'b0; req_full = 1'b1;
        chk("R2 rd_valid", 64'(rd_valid), 64'd1);
        d = rd_data;
    endtask

    task automatic irq(input int v);
        @(negedge clk);
        irq_valid = 1'b1; irq_vec = 4'(v);
        @(negedge clk);
        irq_valid = 1'b0;
    endtask

    task automatic exp_msg(input string tag, input int v);
        chk({tag, " msg_valid"}, 64'(msg_valid), 64'd1);
        chk({tag, " msg_addr"}, msg_addr, {a_hi(v), a_lo(v)});
        chk({tag, " msg_data"}, 64'(msg_data), 64'(dat(v)));
    endtask

    task automatic exp_pend(input string tag, input logic [31:0] e);
        logic [31:0] d;
        rd(12'h800, d);
        chk(tag, 64'(d), 64'(e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 msg_valid", 64'(msg_valid), 64'd0);
        for (int v = 0; v < NV; v++) begin
            rd(12'(16*v + 12), d); chk("R1 ctrl", 64'(d), 64'd1);
            rd(12'(16*v), d);      chk("R1 addr_lo", 64'(d), 64'd0);
            rd(12'(16*v + 8), d);  chk("R1 data", 64'(d), 64'd0);
        end
        exp_pend("R1 pending", 32'h0);

        // R11 capability constants
        chk("R11 qsize", 64'(cap_qsize), 64'(NV - 1));
        chk("R11 table word", 64'(cap_table_word), 64'(RG));
        chk("R11 pba word", 64'(cap_pba_word), 64'(32'h800 | 32'(RG)));

        // R2 layout sweep
        for (int v = 0; v < NV; v++) begin
            wr(12'(16*v), a_lo(v));
            wr(12'(16*v + 4), a_hi(v));
            wr(12'(16*v + 8), dat(v));
            wr(12'(16*v + 12), 32'hFFFF_FFFF);
        end
        for (int v = 0; v < NV; v++) begin
            rd(12'(16*v), d);      chk("R2 addr_lo", 64'(d), 64'(a_lo(v)));
            rd(12'(16*v + 4), d);  chk("R2 addr_hi", 64'(d), 64'(a_hi(v)));
            rd(12'(16*v + 8), d);  chk("R2 data", 64'(d), 64'(dat(v)));
            rd(12'(16*v + 12), d); chk("R2 ctrl only bit0", 64'(d), 64'd1);
        end

        // R9 out-of-range entries
        wr(12'h080, 32'h1234_5678);
        rd(12'h080, d); chk("R9 oor read", 64'(d), 64'd0);
        rd(12'h08C, d); chk("R9 oor ctrl", 64'(d), 64'd0);
        rd(12'h7F0, d); chk("R9 top entry", 64'(d), 64'd0);
        rd(12'h000, d); chk("R9 entry0 intact", 64'(d), 64'(a_lo(0)));

        // R10 sub-word accesses
        wr(12'h010, 32'h0, 1'b0);
        rd(12'h010, d);       chk("R10 subword write ignored", 64'(d), 64'(a_lo(1)));
        rd(12'h010, d, 1'b0); chk("R10 subword read zero", 64'(d), 64'd0);

        // R4 masked entries defer
        func_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            irq(v);
            chk("R4 masked no msg", 64'(msg_valid), 64'd0);
        end
        exp_pend("R4 all pending", 32'hFF);

        // R6 unmask releases one by one
        for (int v = 0; v < NV; v++) begin
            wr(12'(16*v + 12), 32'h0);
            @(negedge clk);
            exp_msg("R6 release", v);
            exp_pend("R6 remaining", 32'((32'hFF << (v + 1)) & 32'hFF));
        end

        // R3 direct delivery
        for (int v = 0; v < NV; v++) begin
            irq(v);
            exp_msg("R3 direct", v);
        end
        exp_pend("R3 no pending", 32'h0);

        // R9 out-of-range vector
        irq(NV);
        chk("R9 oor irq no msg", 64'(msg_valid), 64'd0);
        exp_pend("R9 oor irq no pending", 32'h0);

        // R4 mask-all, R7 ordered release
        func_mask_all = 1'b1;
        irq(6); chk("R4 mask_all no msg", 64'(msg_valid), 64'd0);
        irq(1); irq(3);
        exp_pend("R4 mask_all pending", 32'h4A);
        @(negedge clk); func_mask_all = 1'b0;
        @(negedge clk); exp_msg("R7 first", 1);
        @(negedge clk); exp_msg("R7 second", 3);
        @(negedge clk); exp_msg("R7 third", 6);
        @(negedge clk); chk("R7 drained", 64'(msg_valid), 64'd0);
        exp_pend("R7 pending clear", 32'h0);

        // R4 / R7 enable gating
        func_en = 1'b0;
        irq(2); chk("R4 disabled no msg", 64'(msg_valid), 64'd0);
        exp_pend("R4 disabled pending", 32'h04);
        @(negedge clk); func_en = 1'b1;
        @(negedge clk); exp_msg("R7 enable release", 2);

        // R8 collision of release and fresh interrupt
        wr(12'h02C, 32'h1);
        irq(2);
        chk("R8 masked no msg", 64'(msg_valid), 64'd0);
        wr(12'h02C, 32'h0);
        irq_valid = 1'b1; irq_vec = 4'd5;
        @(negedge clk); irq_valid = 1'b0;
        exp_msg("R8 release first", 2);
        @(negedge clk); exp_msg("R8 fresh later", 5);
        exp_pend("R8 pending clear", 32'h0);

        // R5 pending window
        wr(12'h00C, 32'h1);
        irq(0);
        wr(12'h800, 32'hFFFF_FFFF);
        exp_pend("R5 write ignored", 32'h1);
        rd(12'h804, d); chk("R5 upper word", 64'(d), 64'd0);
        rd(12'h808, d); chk("R5 beyond window", 64'(d), 64'd0);
        rd(12'h800, d, 1'b0); chk("R10 pba subword", 64'(d), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule